// File: doc/BRIEF.md
# I2C Target Receiver with Selectable Clock-Stretch Point

This block is the receive side of an I2C target. It watches oversampled SCL and SDA lines and pulls either line low through open-drain enables. It detects start and stop conditions and shifts in bytes MSB first. It checks the first byte after a start against a programmed 7-bit local address. When a byte needs attention from software, the block holds SCL low to stretch the clock and fires a transfer interrupt. The hold stays until software pulses a release strobe.

Software sets three control bits through a small write port. One enables the acknowledge for data bytes and extension codes. One picks the hold point for data bytes: after the 8th falling SCL edge, so software can decide the acknowledge, or after the 9th. One enables the stop interrupt. A separate wake-up mode input suppresses the stop interrupt. The address byte follows fixed rules whatever the hold-point bit says. A matching address is always acknowledged and held after the 9th edge. An extension code is held after the 8th edge. Any other address sends the block back to idle.

Top module: `i2c_tgt_waitctl`

## Requirements
- R1: After reset, `ctl_rdata_o` reads 0 and `scl_low_o`, `sda_low_o`, `xfer_irq_o`, `xfer_flag_o` and `stop_irq_o` are all 0.
- R2: A cycle with `ctl_we_i` high loads `ctl_wdata_i` into the control bits, laid out as bit 0 acknowledge enable, bit 1 hold point (0 = 8th falling edge, 1 = 9th) and bit 2 stop-interrupt enable. The bits read back on `ctl_rdata_o`, and they do not change while `ctl_we_i` is low.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bits are sampled on SCL rising edges, MSB first. The falling edge that closes the start is not counted as a clock.
- R4: When the upper seven bits of the address byte equal `own_addr_i` and the byte is not an extension code, SDA is pulled low for the 9th clock whatever the acknowledge-enable bit says. SCL is then held and a transfer interrupt fires at the 9th falling edge, whatever the hold-point bit says.
- R5: An address byte whose four upper bits are 0000 or 1111 is an extension code. SCL is held and an interrupt fires at the 8th falling edge. SDA is pulled low in the 9th clock only if acknowledge enable is 1. `ext_code_o` stays high until the next start.
- R6: An address byte that neither matches nor is an extension code gets no acknowledge, no hold and no interrupt. Later bytes are ignored in the same way until the next start.
- R7: For a data byte after an accepted address, the hold and interrupt fall at the 8th falling edge when the hold-point bit is 0, and at the 9th when it is 1.
- R8: For a data byte, SDA is pulled low during the 9th clock exactly when acknowledge enable is 1, and it is released after the 9th falling edge.
- R9: Once SCL is held, it stays held until a `release_i` pulse.
- R10: `xfer_irq_o` is a one-cycle pulse. `xfer_flag_o` sets with it and stays set until `status_clr_i`. A set in the same cycle wins over the clear.
- R11: A stop gives a one-cycle `stop_irq_o` only when stop-interrupt enable is 1 and `wake_mode_i` is 0.
- R12: `rx_byte_o` shows the last byte received, from the 8th falling edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL bus level |
| sda_i | input | 1 | Sensed SDA bus level |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| own_addr_i | input | BYTE_W-1 | Local 7-bit address |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 3 | Control write data |
| ctl_rdata_o | output | 3 | Control bits read back |
| wake_mode_i | input | 1 | Suppresses the stop interrupt when 1 |
| release_i | input | 1 | Release pulse for a held SCL |
| status_clr_i | input | 1 | Clears the sticky transfer flag |
| xfer_irq_o | output | 1 | Transfer interrupt pulse |
| xfer_flag_o | output | 1 | Sticky transfer status |
| stop_irq_o | output | 1 | Stop interrupt pulse |
| rx_byte_o | output | BYTE_W | Last received byte |
| ext_code_o | output | 1 | Current transfer began with an extension code |
| addr_hit_o | output | 1 | Current transfer began with a matching address |

## Verification
The hardest case to reach is a bus master running into its own stretched clock. A hold at the 8th edge must block the 9th rising edge until software releases it, and the acknowledge level must then be sampled on the bus, not at the enable pin. The bench models the bus as a wired-AND of its own master and the block's pull-downs, and the master waits for SCL to actually go high. Each transfer pulses the release only after checking the hold. A sweep over all sixteen control and wake settings, crossed with matching, two kinds of extension code and a foreign address, covers every hold-point and acknowledge combination.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam int CTL_W      = 3;
  localparam int CTL_ACK    = 0;
  localparam int CTL_LATE   = 1;
  localparam int CTL_STOPIE = 2;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  localparam int LAST = SYNC_STAGES - 1;

  // one extra stage beyond the synchroniser gives the previous level
  logic [SYNC_STAGES:0] scl_sh;
  logic [SYNC_STAGES:0] sda_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[LAST:0], scl_i};
      sda_sh <= {sda_sh[LAST:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_sh[LAST];
  assign scl_prev = scl_sh[SYNC_STAGES];
  assign sda_now  = sda_sh[LAST];
  assign sda_prev = sda_sh[SYNC_STAGES];

  assign sda_lvl  = sda_now;
  assign scl_rise = scl_now & ~scl_prev;
  assign scl_fall = ~scl_now & scl_prev;
  assign start_p  = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_p   = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/i2c_tgt_ctl.sv
module i2c_tgt_ctl
  import i2c_tgt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end

  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [BYTE_W-2:0] own_addr,
  input  logic              hold_late,
  output phase_e            phase_q,
  output logic              wait_evt_q,
  output logic              in_ack_q,
  output logic              ack_force_q,
  output logic              ext_q,
  output logic              match_q,
  output logic [BYTE_W-1:0] rx_q
);

  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;

  logic ext_now, match_now;
  assign ext_now   = (sh_q[BYTE_W-1 -: 4] == 4'h0) || (sh_q[BYTE_W-1 -: 4] == 4'hF);
  assign match_now = !ext_now && (sh_q[BYTE_W-1:1] == own_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      rx_q        <= '0;
      in_ack_q    <= 1'b0;
      ack_force_q <= 1'b0;
      ext_q       <= 1'b0;
      match_q     <= 1'b0;
      wait_evt_q  <= 1'b0;
    end else begin
      wait_evt_q <= 1'b0;
      if (start_p) begin
        phase_q     <= PH_ADDR;
        cnt_q       <= '0;
        in_ack_q    <= 1'b0;
        ack_force_q <= 1'b0;
        ext_q       <= 1'b0;
        match_q     <= 1'b0;
      end else if (stop_p) begin
        phase_q     <= PH_IDLE;
        cnt_q       <= '0;
        in_ack_q    <= 1'b0;
        ack_force_q <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise) begin
          if (cnt_q < CNT_LAST) sh_q <= {sh_q[BYTE_W-2:0], sda_lvl};
          if (cnt_q < CNT_ACK)  cnt_q <= cnt_q + 1'b1;
        end else if (scl_fall) begin
          if (cnt_q == CNT_LAST) begin
            rx_q <= sh_q;
            if (phase_q == PH_ADDR) begin
              if (ext_now) begin
                ext_q       <= 1'b1;
                in_ack_q    <= 1'b1;
                ack_force_q <= 1'b0;
                wait_evt_q  <= 1'b1;
              end else if (match_now) begin
                match_q     <= 1'b1;
                in_ack_q    <= 1'b1;
                ack_force_q <= 1'b1;
              end else begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
              end
            end else begin
              in_ack_q    <= 1'b1;
              ack_force_q <= 1'b0;
              wait_evt_q  <= !hold_late;
            end
          end else if (cnt_q == CNT_ACK) begin
            cnt_q       <= '0;
            in_ack_q    <= 1'b0;
            ack_force_q <= 1'b0;
            if (phase_q == PH_ADDR) begin
              phase_q    <= PH_DATA;
              wait_evt_q <= match_q;
            end else begin
              wait_evt_q <= hold_late;
            end
          end
        end
      end
    end
  end

  // R6
  idle_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |-> !in_ack_q);

  // R4
  force_only_match_chk: assert property (@(posedge clk) disable iff (rst)
    ack_force_q |-> (match_q && in_ack_q));

  // R5
  ext_not_match_chk: assert property (@(posedge clk) disable iff (rst)
    !(ext_q && match_q));

endmodule

// File: rtl/i2c_tgt_resp.sv
module i2c_tgt_resp (
  input  logic clk,
  input  logic rst,
  input  logic wait_evt,
  input  logic in_ack,
  input  logic ack_force,
  input  logic ack_en,
  input  logic stop_p,
  input  logic stop_ie,
  input  logic wake_mode,
  input  logic release_p,
  input  logic status_clr,
  output logic scl_hold_q,
  output logic sda_low_q,
  output logic xfer_irq_q,
  output logic xfer_flag_q,
  output logic stop_irq_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_hold_q  <= 1'b0;
      sda_low_q   <= 1'b0;
      xfer_irq_q  <= 1'b0;
      xfer_flag_q <= 1'b0;
      stop_irq_q  <= 1'b0;
    end else begin
      if (wait_evt)       scl_hold_q <= 1'b1;
      else if (release_p) scl_hold_q <= 1'b0;
      xfer_irq_q  <= wait_evt;
      xfer_flag_q <= wait_evt | (xfer_flag_q & ~status_clr);
      stop_irq_q  <= stop_p & stop_ie & ~wake_mode;
      sda_low_q   <= in_ack & (ack_force | ack_en);
    end
  end

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_irq_q |=> !xfer_irq_q);

  // R10
  flag_follows_irq_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_irq_q |-> xfer_flag_q);

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_hold_q && !release_p) |=> scl_hold_q);

  // R7
  irq_with_hold_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_irq_q |-> scl_hold_q);

endmodule

// File: rtl/i2c_tgt_waitctl.sv
module i2c_tgt_waitctl
  import i2c_tgt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic [BYTE_W-2:0] own_addr_i,
  input  logic              ctl_we_i,
  input  logic [2:0]        ctl_wdata_i,
  output logic [2:0]        ctl_rdata_o,
  input  logic              wake_mode_i,
  input  logic              release_i,
  input  logic              status_clr_i,
  output logic              xfer_irq_o,
  output logic              xfer_flag_o,
  output logic              stop_irq_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              ext_code_o,
  output logic              addr_hit_o
);

  logic sda_lvl, scl_rise, scl_fall, start_p, stop_p;
  logic [CTL_W-1:0] ctl_q;
  phase_e phase;
  logic wait_evt, in_ack, ack_force;

  i2c_tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  i2c_tgt_ctl ctl_i (
    .clk(clk), .rst(rst), .we(ctl_we_i), .wdata(ctl_wdata_i), .q(ctl_q)
  );

  i2c_tgt_engine #(.BYTE_W(BYTE_W)) eng_i (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p),
    .own_addr(own_addr_i), .hold_late(ctl_q[CTL_LATE]),
    .phase_q(phase), .wait_evt_q(wait_evt), .in_ack_q(in_ack),
    .ack_force_q(ack_force), .ext_q(ext_code_o), .match_q(addr_hit_o),
    .rx_q(rx_byte_o)
  );

  i2c_tgt_resp resp_i (
    .clk(clk), .rst(rst), .wait_evt(wait_evt), .in_ack(in_ack),
    .ack_force(ack_force), .ack_en(ctl_q[CTL_ACK]),
    .stop_p(stop_p), .stop_ie(ctl_q[CTL_STOPIE]), .wake_mode(wake_mode_i),
    .release_p(release_i), .status_clr(status_clr_i),
    .scl_hold_q(scl_low_o), .sda_low_q(sda_low_o),
    .xfer_irq_q(xfer_irq_o), .xfer_flag_q(xfer_flag_o),
    .stop_irq_q(stop_irq_o)
  );

  assign ctl_rdata_o = ctl_q;

  // R11
  stop_irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_irq_o |-> (phase == PH_IDLE));

endmodule

// File: tb/i2c_tgt_waitctl_tb_top.sv
module i2c_tgt_waitctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 6;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_bus, sda_bus;
  logic scl_low_o, sda_low_o;
  logic ctl_we_i = 1'b0;
  logic [2:0] ctl_wdata_i = 3'd0;
  logic [2:0] ctl_rdata_o;
  logic wake_mode_i = 1'b0, release_i = 1'b0, status_clr_i = 1'b0;
  logic xfer_irq_o, xfer_flag_o, stop_irq_o;
  logic [7:0] rx_byte_o;
  logic ext_code_o, addr_hit_o;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_cnt = 0;
  int stop_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_bus = scl_m & ~scl_low_o;
  assign sda_bus = sda_m & ~sda_low_o;

  i2c_tgt_waitctl dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .own_addr_i(OWN),
    .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i), .ctl_rdata_o(ctl_rdata_o),
    .wake_mode_i(wake_mode_i), .release_i(release_i), .status_clr_i(status_clr_i),
    .xfer_irq_o(xfer_irq_o), .xfer_flag_o(xfer_flag_o), .stop_irq_o(stop_irq_o),
    .rx_byte_o(rx_byte_o), .ext_code_o(ext_code_o), .addr_hit_o(addr_hit_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (xfer_irq_o) irq_cnt++;
      if (stop_irq_o) stop_cnt++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_scl_high();
    int t = 0;
    while (scl_bus !== 1'b1 && t < 2000) begin tick(); t++; end
    check(t < 2000, "R9 SCL never released", t, 0);
  endtask

  task automatic drive_bit(input logic b);
    sda_m = b; wait_n(W);
    scl_m = 1'b1; wait_scl_high(); wait_n(W);
    scl_m = 1'b0; wait_n(W);
  endtask

  task automatic pulse_release();
    release_i = 1'b1; tick(); release_i = 1'b0; wait_n(2);
    check(scl_low_o == 1'b0, "R9 hold cleared by release", scl_low_o, 0);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_n(W);
    sda_m = 1'b0; wait_n(W);
    scl_m = 1'b0; wait_n(W);
  endtask

  task automatic bus_stop(input bit exp_irq);
    int s0;
    sda_m = 1'b0; wait_n(W);
    scl_m = 1'b1; wait_scl_high(); wait_n(W);
    s0 = stop_cnt;
    sda_m = 1'b1; wait_n(W);
    check((stop_cnt - s0) == int'(exp_irq), "R11 stop interrupt count", stop_cnt - s0, int'(exp_irq));
  endtask

  // one byte plus its acknowledge clock, checking the hold point and ACK level
  task automatic do_byte(input logic [7:0] b, input bit h8, input bit ack,
                         input bit h9, input bit chk_rx, input string tag);
    int c0;
    c0 = irq_cnt;
    for (int i = 7; i >= 0; i--) drive_bit(b[i]);
    check(scl_low_o == h8, {tag, " hold after 8th falling edge"}, scl_low_o, h8);
    check((irq_cnt - c0) == int'(h8), {tag, " interrupts at 8th edge"}, irq_cnt - c0, h8);
    check(sda_low_o == ack, {tag, " ACK drive R8"}, sda_low_o, ack);
    if (chk_rx) check(rx_byte_o == b, "R12 received byte", rx_byte_o, b);
    if (h8) begin
      check(xfer_flag_o == 1'b1, "R10 flag set", xfer_flag_o, 1);
      status_clr_i = 1'b1; tick(); status_clr_i = 1'b0; wait_n(1);
      check(xfer_flag_o == 1'b0, "R10 flag cleared", xfer_flag_o, 0);
      wait_n(W);
      check(scl_low_o == 1'b1, "R9 hold persists", scl_low_o, 1);
      pulse_release();
    end
    sda_m = 1'b1; wait_n(W);
    scl_m = 1'b1; wait_scl_high(); wait_n(W);
    check(sda_bus == !ack, {tag, " ACK level on bus in 9th clock"}, sda_bus, !ack);
    scl_m = 1'b0; wait_n(W);
    check(scl_low_o == h9, {tag, " hold after 9th falling edge"}, scl_low_o, h9);
    check((irq_cnt - c0) == int'(h8) + int'(h9), {tag, " interrupt total"}, irq_cnt - c0, int'(h8) + int'(h9));
    check(sda_low_o == 1'b0, "R8 SDA released after 9th edge", sda_low_o, 0);
    if (h9) pulse_release();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [7:0] addrs [4];
    addrs[0] = {OWN, 1'b0};
    addrs[1] = 8'h06;
    addrs[2] = 8'hF2;
    addrs[3] = {OWN + 7'd1, 1'b0};
    wait_n(4);
    rst = 1'b0; wait_n(1);
    // R1
    check(ctl_rdata_o == 3'd0, "R1 control reset", ctl_rdata_o, 0);
    check(scl_low_o == 1'b0 && sda_low_o == 1'b0, "R1 drives released", {scl_low_o, sda_low_o}, 0);
    check(xfer_flag_o == 1'b0 && xfer_irq_o == 1'b0 && stop_irq_o == 1'b0, "R1 interrupts clear",
          {xfer_flag_o, xfer_irq_o, stop_irq_o}, 0);

    for (int cfg = 0; cfg < 16; cfg++) begin
      bit ack_en, late, sie, wake;
      ack_en = cfg[0]; late = cfg[1]; sie = cfg[2]; wake = cfg[3];
      ctl_wdata_i = {sie, late, ack_en}; ctl_we_i = 1'b1; tick(); ctl_we_i = 1'b0;
      wake_mode_i = wake;
      ctl_wdata_i = ~{sie, late, ack_en}; wait_n(2);
      check(ctl_rdata_o == {sie, late, ack_en}, "R2 control write and hold",
            ctl_rdata_o, {sie, late, ack_en});
      for (int ai = 0; ai < 4; ai++) begin
        logic [7:0] a, d;
        bit ext, hit, act, aack;
        a    = addrs[ai];
        ext  = (a[7:4] == 4'h0) || (a[7:4] == 4'hF);
        hit  = !ext && (a[7:1] == OWN);
        act  = ext || hit;
        aack = hit ? 1'b1 : (ext ? ack_en : 1'b0);
        d    = 8'(cfg * 29 + ai * 71 + 8'h33);
        bus_start();
        // R3 R4 R5 R6: address byte rules
        do_byte(a, ext, aack, hit, act, hit ? "R4 match" : (ext ? "R5 ext" : "R6 foreign"));
        // R7 R8 (or R6 when the address was foreign)
        do_byte(d, act && !late, act && ack_en, act && late, act, act ? "R7 data" : "R6 ignored");
        check(ext_code_o == ext, "R5 extension flag", ext_code_o, ext);
        check(addr_hit_o == hit, "R4 match flag", addr_hit_o, hit);
        bus_stop(sie && !wake);
        wait_n(W);
      end
    end
    finish_run();
  end

endmodule